// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block holds decoded instructions that are waiting to run on one functional unit. When an instruction is dispatched, each of its two source operands arrives either as a finished value or as the tag of the instruction that will produce that value. Tag zero means the operand is already present. Producer tags are never zero. Every occupied slot watches a single result-broadcast bus. When the bus carries a tag that a slot is waiting for, the slot copies the value and marks that operand present.

Once both operands of an entry are present, the entry may go to the functional unit. When several entries are ready, the one dispatched earliest goes first, whichever slot it occupies. An issued entry releases its slot in the cycle it issues, so a new dispatch can land in that slot in the same cycle. Each entry also carries a speculative flag. A flush input removes every entry with that flag set and leaves the other entries in place.

Renaming, the functional unit and bus arbitration all live outside the block. Tags, values and the broadcast reach it as plain inputs.

Top module: `rs_station`

## Requirements
- R1: After reset no entry is occupied, `iss_valid` is 0 and `full` is 0.
- R2: At dispatch, an operand with tag 0 is stored as the given value. An operand with a nonzero tag waits until a broadcast with that tag arrives. An entry with a waiting operand never issues.
- R3: When `bc_valid` is high and `bc_tag` equals a waiting tag of an occupied entry, that operand takes `bc_val`. Both operands of one entry may be filled by the same broadcast.
- R4: When a dispatched operand's nonzero tag equals `bc_tag` while `bc_valid` is high in the dispatch cycle, the operand takes `bc_val` directly.
- R5: An entry whose operands are both present is issued when `fu_ready` is high. Issue happens no earlier than the cycle after dispatch or capture. `iss_valid` is then high combinationally, with the entry's opcode, both operand values and its destination tag.
- R6: Among ready entries, the one dispatched earliest is issued, independent of slot position.
- R7: `full` is 1 exactly when every slot is occupied and no entry issues in that cycle. A dispatch while `full` is 1 is ignored. A slot freed by issue accepts a dispatch in the same cycle.
- R8: When `flush` is high, all entries with the speculative flag are removed and entries without it remain. No issue occurs and any dispatch is ignored in that cycle.
- R9: A broadcast whose tag matches no waiting operand changes no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Tag the dispatched instruction will produce |
| disp_spec | input | 1 | Dispatched instruction lies on a speculative path |
| disp_tag_a | input | TAG_W | Producer tag of operand A, 0 when the value is present |
| disp_val_a | input | DATA_W | Value of operand A |
| disp_tag_b | input | TAG_W | Producer tag of operand B, 0 when the value is present |
| disp_val_b | input | DATA_W | Value of operand B |
| full | output | 1 | No slot can accept a dispatch this cycle |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Functional unit accepts an instruction this cycle |
| flush | input | 1 | Remove all speculative entries |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued entry |
| iss_opnd_a | output | DATA_W | Operand A of the issued entry |
| iss_opnd_b | output | DATA_W | Operand B of the issued entry |
| iss_dst | output | TAG_W | Destination tag of the issued entry |

## Verification
The hardest case to reach is an age order that differs from slot order. It needs an old entry in a high slot, a young entry in a low slot, and both ready in the same cycle. The stimulus fills every slot with waiting entries, issues the one in slot 0, and refills slot 0 with a ready instruction. It then wakes the older entries while the functional unit is held busy, so three ready entries compete in reverse slot order. A long random phase mixes dispatches against a full pool, repeated tags, same-cycle bypass and flushes, and a queue-based reference model checks every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int unsigned RS_ENTRIES_DEF = 4;
    localparam int unsigned RS_TAG_W_DEF   = 4;
    localparam int unsigned RS_DATA_W_DEF  = 16;
    localparam int unsigned RS_OP_W_DEF    = 5;
endpackage

// File: rtl/rs_operand_capture.sv
module rs_operand_capture #(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [DATA_W-1:0] cur_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic [TAG_W-1:0]  nxt_tag,
    output logic [DATA_W-1:0] nxt_val
);
    logic hit;

    // A zero tag means the operand is present, so it never matches.
    assign hit     = bc_valid && (cur_tag != '0) && (cur_tag == bc_tag);
    assign nxt_tag = hit ? '0 : cur_tag;
    assign nxt_val = hit ? bc_val : cur_val;
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [ENTRIES-1:0]            cand,
    input  logic [ENTRIES-1:0][IDX_W-1:0] rank,
    output logic                          found,
    output logic [IDX_W-1:0]              idx
);
    logic [IDX_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (cand[i] && (!found || rank[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = rank[i];
            end
        end
    end
endmodule

// File: rtl/rs_free_find.sv
module rs_free_find #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [ENTRIES-1:0] avail,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_rank_compact.sv
module rs_rank_compact #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned IDX_W   = 2,
    parameter int unsigned CNT_W   = 3
) (
    input  logic [ENTRIES-1:0]            keep,
    input  logic [ENTRIES-1:0][IDX_W-1:0] rank,
    output logic [ENTRIES-1:0][IDX_W-1:0] new_rank,
    output logic [CNT_W-1:0]              keep_cnt
);
    // A surviving entry's new rank is the number of survivors older than it.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        always_comb begin
            int unsigned older;
            older = 0;
            for (int j = 0; j < int'(ENTRIES); j++) begin
                if (keep[j] && rank[j] < rank[g]) older++;
            end
            new_rank[g] = IDX_W'(older);
        end
    end

    always_comb begin
        keep_cnt = '0;
        for (int j = 0; j < int'(ENTRIES); j++) begin
            keep_cnt = keep_cnt + CNT_W'(keep[j]);
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int unsigned ENTRIES = RS_ENTRIES_DEF,
    parameter int unsigned TAG_W   = RS_TAG_W_DEF,
    parameter int unsigned DATA_W  = RS_DATA_W_DEF,
    parameter int unsigned OP_W    = RS_OP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic              disp_spec,
    input  logic [TAG_W-1:0]  disp_tag_a,
    input  logic [DATA_W-1:0] disp_val_a,
    input  logic [TAG_W-1:0]  disp_tag_b,
    input  logic [DATA_W-1:0] disp_val_b,
    output logic              full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              fu_ready,
    input  logic              flush,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_opnd_a,
    output logic [DATA_W-1:0] iss_opnd_b,
    output logic [TAG_W-1:0]  iss_dst
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic              busy;
        logic              spec;
        logic [IDX_W-1:0]  rank;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic [TAG_W-1:0]  tag_a;
        logic [TAG_W-1:0]  tag_b;
        logic [DATA_W-1:0] val_a;
        logic [DATA_W-1:0] val_b;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]             busy_vec, spec_vec, rdy_vec, keep;
    logic [ENTRIES-1:0][IDX_W-1:0]  rank_arr, new_rank;
    logic [ENTRIES-1:0][TAG_W-1:0]  cap_tag_a, cap_tag_b;
    logic [ENTRIES-1:0][DATA_W-1:0] cap_val_a, cap_val_b;
    logic [TAG_W-1:0]               dtag_a, dtag_b;
    logic [DATA_W-1:0]              dval_a, dval_b;
    logic [CNT_W-1:0]               keep_cnt;
    logic                           pick_found, alloc_found;
    logic [IDX_W-1:0]               iss_idx, alloc_idx;
    logic                           iss_fire, disp_fire;

    // Per-slot view and broadcast capture
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign busy_vec[g] = st_q.slot[g].busy;
        assign spec_vec[g] = st_q.slot[g].spec;
        assign rank_arr[g] = st_q.slot[g].rank;
        assign rdy_vec[g]  = st_q.slot[g].busy && (st_q.slot[g].tag_a == '0)
                             && (st_q.slot[g].tag_b == '0);

        rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cap_a (
            .cur_tag (st_q.slot[g].tag_a),
            .cur_val (st_q.slot[g].val_a),
            .bc_valid(bc_valid),
            .bc_tag  (bc_tag),
            .bc_val  (bc_val),
            .nxt_tag (cap_tag_a[g]),
            .nxt_val (cap_val_a[g])
        );
        rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cap_b (
            .cur_tag (st_q.slot[g].tag_b),
            .cur_val (st_q.slot[g].val_b),
            .bc_valid(bc_valid),
            .bc_tag  (bc_tag),
            .bc_val  (bc_val),
            .nxt_tag (cap_tag_b[g]),
            .nxt_val (cap_val_b[g])
        );
    end

    // Same-cycle capture for the operands being dispatched
    rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_disp_cap_a (
        .cur_tag (disp_tag_a),
        .cur_val (disp_val_a),
        .bc_valid(bc_valid),
        .bc_tag  (bc_tag),
        .bc_val  (bc_val),
        .nxt_tag (dtag_a),
        .nxt_val (dval_a)
    );
    rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_disp_cap_b (
        .cur_tag (disp_tag_b),
        .cur_val (disp_val_b),
        .bc_valid(bc_valid),
        .bc_tag  (bc_tag),
        .bc_val  (bc_val),
        .nxt_tag (dtag_b),
        .nxt_val (dval_b)
    );

    // Oldest-ready selection
    rs_oldest_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .cand (rdy_vec),
        .rank (rank_arr),
        .found(pick_found),
        .idx  (iss_idx)
    );

    assign iss_fire   = pick_found && fu_ready && !flush;
    assign iss_valid  = iss_fire;
    assign iss_op     = st_q.slot[iss_idx].op;
    assign iss_opnd_a = st_q.slot[iss_idx].val_a;
    assign iss_opnd_b = st_q.slot[iss_idx].val_b;
    assign iss_dst    = st_q.slot[iss_idx].dst;

    // Slots that survive this cycle
    always_comb begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            keep[i] = busy_vec[i]
                      && !(iss_fire && iss_idx == IDX_W'(i))
                      && !(flush && spec_vec[i]);
        end
    end

    rs_rank_compact #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rank (
        .keep    (keep),
        .rank    (rank_arr),
        .new_rank(new_rank),
        .keep_cnt(keep_cnt)
    );

    rs_free_find #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_free (
        .avail(~keep),
        .found(alloc_found),
        .idx  (alloc_idx)
    );

    assign full      = (&busy_vec) && !iss_fire;
    assign disp_fire = disp_valid && !full && !flush && alloc_found;

    // Next-state process
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            st_d.slot[i].busy  = keep[i];
            st_d.slot[i].rank  = new_rank[i];
            st_d.slot[i].tag_a = cap_tag_a[i];
            st_d.slot[i].val_a = cap_val_a[i];
            st_d.slot[i].tag_b = cap_tag_b[i];
            st_d.slot[i].val_b = cap_val_b[i];
            if (disp_fire && alloc_idx == IDX_W'(i)) begin
                st_d.slot[i].busy  = 1'b1;
                st_d.slot[i].spec  = disp_spec;
                st_d.slot[i].rank  = IDX_W'(keep_cnt);
                st_d.slot[i].op    = disp_op;
                st_d.slot[i].dst   = disp_dst;
                st_d.slot[i].tag_a = dtag_a;
                st_d.slot[i].val_a = dval_a;
                st_d.slot[i].tag_b = dtag_b;
                st_d.slot[i].val_b = dval_b;
            end
        end
    end

    // Register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Assertions
    logic older_rdy;
    always_comb begin
        older_rdy = 1'b0;
        for (int j = 0; j < int'(ENTRIES); j++) begin
            if (rdy_vec[j] && rank_arr[j] < rank_arr[iss_idx]) older_rdy = 1'b1;
        end
    end

    AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !older_rdy); // R6

    AST_ISSUED_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !disp_fire |=> !busy_vec[$past(iss_idx)]); // R5

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((busy_vec & spec_vec) == '0)); // R8

    AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && full |=> $countones(busy_vec) <= $past($countones(busy_vec))); // R7

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        AST_NONSPEC_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
            flush && busy_vec[g] && !spec_vec[g] |=> busy_vec[g]); // R8

        AST_WAKE_A: assert property (@(posedge clk) disable iff (!rst_n)
            busy_vec[g] && bc_valid && st_q.slot[g].tag_a != '0
            && st_q.slot[g].tag_a == bc_tag |=> st_q.slot[g].tag_a == '0); // R3
    end
endmodule

// File: tb/tb_rs_station.sv
module tb_rs_station;
    localparam int N  = 4;
    localparam int TW = 4;
    localparam int DW = 16;
    localparam int OW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          disp_valid = 0, disp_spec = 0;
    logic [OW-1:0] disp_op = '0;
    logic [TW-1:0] disp_dst = '0, disp_tag_a = '0, disp_tag_b = '0;
    logic [DW-1:0] disp_val_a = '0, disp_val_b = '0;
    logic          bc_valid = 0, fu_ready = 0, flush = 0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_val = '0;
    logic          full, iss_valid;
    logic [OW-1:0] iss_op;
    logic [DW-1:0] iss_opnd_a, iss_opnd_b;
    logic [TW-1:0] iss_dst;

    rs_station #(.ENTRIES(N), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_spec(disp_spec), .disp_tag_a(disp_tag_a), .disp_val_a(disp_val_a),
        .disp_tag_b(disp_tag_b), .disp_val_b(disp_val_b), .full(full),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .fu_ready(fu_ready), .flush(flush),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_opnd_a(iss_opnd_a),
        .iss_opnd_b(iss_opnd_b), .iss_dst(iss_dst)
    );

    int    checks = 0, fails = 0;
    string cur_req = "R1";
    bit    done = 0;

    // Reference model: a plain pool ordered by a global sequence number
    bit            m_busy[N], m_spec[N];
    int            m_seq[N];
    logic [OW-1:0] m_op[N];
    logic [TW-1:0] m_dst[N], m_ta[N], m_tb[N];
    logic [DW-1:0] m_va[N], m_vb[N];
    int            g_seq = 0;
    bit            e_fire, e_full;
    int            e_idx;

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int cnt = 0;
        e_idx = -1;
        for (int i = 0; i < N; i++) begin
            if (m_busy[i]) cnt++;
            if (m_busy[i] && m_ta[i] == '0 && m_tb[i] == '0
                && (e_idx < 0 || m_seq[i] < m_seq[e_idx])) e_idx = i;
        end
        e_fire = (e_idx >= 0) && fu_ready && !flush;
        e_full = (cnt == N) && !e_fire;
        check(iss_valid === e_fire, "iss_valid", iss_valid, e_fire);
        check(full === e_full, "full", full, e_full);
        if (e_fire && iss_valid) begin
            check(iss_op === m_op[e_idx], "iss_op", iss_op, m_op[e_idx]);
            check(iss_opnd_a === m_va[e_idx], "iss_opnd_a", iss_opnd_a, m_va[e_idx]);
            check(iss_opnd_b === m_vb[e_idx], "iss_opnd_b", iss_opnd_b, m_vb[e_idx]);
            check(iss_dst === m_dst[e_idx], "iss_dst", iss_dst, m_dst[e_idx]);
        end
    endtask

    task automatic model_update();
        for (int i = 0; i < N; i++) begin
            if (bc_valid && m_ta[i] != '0 && m_ta[i] == bc_tag) begin m_ta[i] = '0; m_va[i] = bc_val; end
            if (bc_valid && m_tb[i] != '0 && m_tb[i] == bc_tag) begin m_tb[i] = '0; m_vb[i] = bc_val; end
        end
        if (e_fire) m_busy[e_idx] = 0;
        if (flush) for (int i = 0; i < N; i++) if (m_spec[i]) m_busy[i] = 0;
        if (disp_valid && !e_full && !flush) begin
            int k = -1;
            for (int i = 0; i < N; i++) if (!m_busy[i] && k < 0) k = i;
            m_busy[k] = 1; m_spec[k] = disp_spec; m_seq[k] = g_seq++;
            m_op[k] = disp_op; m_dst[k] = disp_dst;
            m_ta[k] = disp_tag_a; m_va[k] = disp_val_a;
            m_tb[k] = disp_tag_b; m_vb[k] = disp_val_b;
            if (bc_valid && disp_tag_a != '0 && disp_tag_a == bc_tag) begin m_ta[k] = '0; m_va[k] = bc_val; end
            if (bc_valid && disp_tag_b != '0 && disp_tag_b == bc_tag) begin m_tb[k] = '0; m_vb[k] = bc_val; end
        end
    endtask

    task automatic tick();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid = 0; bc_valid = 0; flush = 0; fu_ready = 0; disp_spec = 0;
    endtask

    task automatic disp(input int op, input int dst, input bit spec,
                        input int ta, input int va, input int tb, input int vb);
        disp_valid = 1; disp_op = OW'(op); disp_dst = TW'(dst); disp_spec = spec;
        disp_tag_a = TW'(ta); disp_val_a = DW'(va);
        disp_tag_b = TW'(tb); disp_val_b = DW'(vb);
    endtask

    task automatic bcast(input int tag, input int val);
        bc_valid = 1; bc_tag = TW'(tag); bc_val = DW'(val);
    endtask

    task automatic drain();
        for (int t = 1; t < 16; t++) begin
            idle(); bcast(t, 16'h1000 + t); fu_ready = 1; tick();
        end
        for (int c = 0; c < 6; c++) begin idle(); fu_ready = 1; tick(); end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog: actual running expected finished", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_busy[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check(iss_valid === 1'b0, "iss_valid in reset", iss_valid, 0);
        check(full === 1'b0, "full in reset", full, 0);
        rst_n = 1;
        idle(); tick();

        // R2 / R5: ready operands issue one cycle after dispatch
        cur_req = "R2";
        disp(3, 1, 0, 0, 16'h0011, 0, 16'h0022); tick();
        idle(); fu_ready = 1; tick();
        disp(4, 2, 0, 0, 16'h0033, 3, 16'hDEAD); fu_ready = 1; tick();
        idle(); fu_ready = 1; tick(); tick();

        // R3: capture, including both operands from one broadcast
        cur_req = "R3";
        idle(); bcast(3, 16'hBEEF); fu_ready = 1; tick();
        idle(); fu_ready = 1; tick();
        disp(5, 4, 0, 5, 0, 5, 0); tick();
        idle(); bcast(5, 16'h5A5A); tick();
        idle(); fu_ready = 1; tick();

        // R9: non-matching broadcast has no effect
        cur_req = "R9";
        disp(6, 6, 0, 0, 16'h0606, 6, 16'hFFFF); tick();
        idle(); bcast(7, 16'h7777); fu_ready = 1; tick();
        idle(); fu_ready = 1; tick();
        idle(); bcast(6, 16'h6666); tick();
        idle(); fu_ready = 1; tick();

        // R4: bypass from the bus in the dispatch cycle
        cur_req = "R4";
        disp(7, 8, 0, 8, 16'hAAAA, 0, 16'h0808); bcast(8, 16'h8888); tick();
        idle(); fu_ready = 1; tick();

        // R6: age order differs from slot order
        cur_req = "R6";
        disp(10, 1, 0, 1, 0, 0, 16'h0A0A); tick();
        disp(11, 2, 0, 0, 16'h0B0B, 2, 0); tick();
        disp(12, 3, 0, 3, 0, 0, 16'h0C0C); tick();
        disp(13, 4, 0, 0, 16'h0D0D, 4, 0); tick();
        idle(); bcast(1, 16'h0101); tick();
        idle(); fu_ready = 1; tick();
        disp(14, 5, 0, 0, 16'h0E0E, 0, 16'h0E0F); tick();
        idle(); bcast(2, 16'h0202); tick();
        idle(); bcast(4, 16'h0404); tick();
        for (int c = 0; c < 3; c++) begin idle(); fu_ready = 1; tick(); end
        drain();

        // R7: full, ignored dispatch, same-cycle refill
        cur_req = "R7";
        disp(20, 1, 0, 0, 16'h2020, 0, 16'h2021); tick();
        for (int c = 0; c < 3; c++) begin disp(21 + c, 2 + c, 0, 9, 0, 0, c); tick(); end
        disp(25, 6, 0, 0, 16'h2525, 0, 16'h2526); tick();
        disp(26, 7, 0, 0, 16'h2626, 0, 16'h2627); fu_ready = 1; tick();
        idle(); fu_ready = 1; tick();
        drain();

        // R8: flush removes only speculative entries
        cur_req = "R8";
        disp(30, 1, 0, 10, 0, 0, 16'h3030); tick();
        disp(31, 2, 1, 10, 0, 0, 16'h3131); tick();
        disp(32, 3, 1, 0, 16'h3232, 0, 16'h3233); tick();
        disp(33, 4, 0, 0, 16'h3333, 10, 0); tick();
        idle(); flush = 1; fu_ready = 1; disp(34, 5, 0, 0, 1, 0, 2); tick();
        idle(); bcast(10, 16'h1010); tick();
        for (int c = 0; c < 4; c++) begin idle(); fu_ready = 1; tick(); end
        drain();

        // Mixed random traffic, checked against the model every cycle
        cur_req = "R6";
        for (int c = 0; c < 4000; c++) begin
            idle();
            if ($urandom_range(0, 2) != 0)
                disp($urandom_range(0, 31), $urandom_range(1, 15), $urandom_range(0, 1) == 1,
                     ($urandom_range(0, 1) == 1) ? $urandom_range(1, 5) : 0, $urandom_range(0, 65535),
                     ($urandom_range(0, 1) == 1) ? $urandom_range(1, 5) : 0, $urandom_range(0, 65535));
            if ($urandom_range(0, 1) == 1) bcast($urandom_range(0, 6), $urandom_range(0, 65535));
            fu_ready = $urandom_range(0, 2) != 0;
            flush = $urandom_range(0, 40) == 0;
            tick();
        end
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule